// File: doc/BRIEF.md
# Return-Address and Interrupt Context Stack

This block is the call stack unit of a small microcontroller core. A five-entry address stack holds return addresses and saved address-register values. A 3-bit stack pointer indexes it. The pointer starts at 5 when the stack is empty and counts down as entries are stored. A separate three-level context stack saves the bank register and the program status word together each time an interrupt is taken. It restores them on interrupt return.

The core's decoder issues at most one 4-bit command per clock. Storing commands write `push_data`: call, the first cycle of a table read, address-register push, system call and interrupt accept. Retrieving commands read the top entry back on `pop_data`: return, return-and-skip, the second cycle of a table read, address-register pop and interrupt return. When the pointer moves to 6 or 7, which means more than five nested levels or a return from an empty stack, the block raises a registered request for the chip reset generator. The context stack discards its oldest entry when it overflows, so it never requests a reset.

Top module: `call_stack_unit`

## Requirements
- R1: After reset, `sp_out` is 5, `ctx_free` is 3, and `reset_req`, `pop_data`, `bank_out` and `psw_out` are all zero.
- R2: Command codes 1 (call), 2 (table read, first cycle), 3 (address-register push), 4 (system call) and 5 (interrupt accept) each lower `sp_out` by one, modulo 8, at the next edge. When the new pointer value is below 5, `push_data` is written into the entry at that value.
- R3: Command codes 6 (return), 7 (return and skip), 8 (table read, second cycle), 9 (address-register pop) and 10 (interrupt return) each raise `sp_out` by one, modulo 8, at the next edge. `pop_data` takes the entry at the pointer value before the increment, or zero when that value is 5 or more, and holds it until the next retrieving command.
- R4: Values stored by successive storing commands come back in reverse order on successive retrieving commands.
- R5: `reset_req` is high in the cycle after `sp_out` holds 6 or 7, and low in the cycle after it holds 0 to 5.
- R6: Code 5 saves `bank_in` and `psw_in` together as one context. Code 10 presents the most recently saved context on `bank_out` and `psw_out` after the next edge and removes it from the stack.
- R7: A fourth interrupt accept without an intervening return loses the oldest saved context. Only the three most recent contexts come back, newest first.
- R8: `ctx_free` falls by one on code 5, stopping at 0, and rises by one on code 10, stopping at 3. All other codes leave it unchanged.
- R9: Code 10 with no saved context drives zero on `bank_out` and `psw_out`, and `ctx_free` stays 3.
- R10: Codes 0 and 11 to 15 change neither `sp_out`, `ctx_free`, `pop_data`, `bank_out` nor `psw_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Stack command code, one per clock |
| push_data | input | AW (12) | Return address or address-register value to store |
| bank_in | input | BW (4) | Current bank register |
| psw_in | input | SW (8) | Current program status word |
| pop_data | output | AW (12) | Entry read by the last retrieving command |
| bank_out | output | BW (4) | Bank value restored by the last interrupt return |
| psw_out | output | SW (8) | Status word restored by the last interrupt return |
| sp_out | output | 3 | Stack pointer |
| ctx_free | output | 2 | Free levels in the interrupt context stack |
| reset_req | output | 1 | Request for chip reset, pointer out of range |

## Verification
A command applied before edge k updates `sp_out`, `ctx_free`, `pop_data`, `bank_out` and `psw_out` at edge k. The bench therefore compares these outputs at the falling edge that follows edge k. `reset_req` is registered from the pointer, so it lags by one more edge. At each step the bench compares it against the value its model held for the pointer before the command was applied. Inputs change only on falling edges, so every sample lands half a period away from the edge that produced it.

// File: rtl/cstk_pkg.sv
package cstk_pkg;
  localparam int SP_W = 3;

  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_CALL      = 4'd1,
    CMD_TBL_FETCH = 4'd2,
    CMD_PUSH_AR   = 4'd3,
    CMD_SYSCALL   = 4'd4,
    CMD_INT_ACK   = 4'd5,
    CMD_RET       = 4'd6,
    CMD_RET_SKIP  = 4'd7,
    CMD_TBL_DONE  = 4'd8,
    CMD_POP_AR    = 4'd9,
    CMD_RETI      = 4'd10
  } stk_cmd_e;

  // pointer after one command: storing moves down, retrieving moves up
  function automatic logic [SP_W-1:0] sp_step(input logic [SP_W-1:0] sp,
                                              input logic down, input logic up);
    if (down)    return sp - 1'b1;
    else if (up) return sp + 1'b1;
    else         return sp;
  endfunction

  // a pointer at or above the depth no longer names a storage slot
  function automatic logic sp_outside(input logic [SP_W-1:0] sp, input int depth);
    return int'(sp) >= depth;
  endfunction

  // a pointer above the empty value means too deep or too many returns
  function automatic logic sp_fault(input logic [SP_W-1:0] sp, input int depth);
    return int'(sp) > depth;
  endfunction
endpackage

// File: rtl/cstk_cmd_decode.sv
module cstk_cmd_decode
  import cstk_pkg::*;
(
  input  logic [3:0] cmd,
  output logic       do_push,
  output logic       do_pop,
  output logic       do_int,
  output logic       do_reti
);
  always_comb begin
    do_push = 1'b0;
    do_pop  = 1'b0;
    do_int  = 1'b0;
    do_reti = 1'b0;
    case (cmd)
      CMD_CALL, CMD_TBL_FETCH, CMD_PUSH_AR, CMD_SYSCALL: do_push = 1'b1;
      CMD_INT_ACK: begin do_push = 1'b1; do_int = 1'b1; end
      CMD_RET, CMD_RET_SKIP, CMD_TBL_DONE, CMD_POP_AR: do_pop = 1'b1;
      CMD_RETI: begin do_pop = 1'b1; do_reti = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/cstk_addr_stack.sv
module cstk_addr_stack #(
  parameter int DEPTH = 5,
  parameter int AW    = 12,
  parameter int SPW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [SPW-1:0] wr_idx,
  input  logic [AW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [SPW-1:0] rd_idx,
  output logic [AW-1:0]  rd_data
);
  logic [AW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] wr_hit;
  logic [DEPTH-1:0] rd_hit;
  logic [AW-1:0]    rd_mux;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign wr_hit[g] = wr_en && (wr_idx == SPW'(g));
    assign rd_hit[g] = (rd_idx == SPW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_hit[i]) slot[i] <= wr_data;
    end
  end

  // an index past the last slot selects nothing and reads as zero
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_hit[i]) rd_mux = slot[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/cstk_ctx_stack.sv
module cstk_ctx_stack #(
  parameter int LEVELS = 3,
  parameter int BW     = 4,
  parameter int SW     = 8,
  localparam int CW    = $clog2(LEVELS + 1),
  localparam int EW    = BW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save,
  input  logic          restore,
  input  logic [BW-1:0] bank_in,
  input  logic [SW-1:0] psw_in,
  output logic [BW-1:0] bank_out,
  output logic [SW-1:0] psw_out,
  output logic [CW-1:0] free_cnt
);
  // level 0 is the newest context; zeros shift in behind a restore
  logic [EW-1:0] lvl [LEVELS];
  logic [EW-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LEVELS; i++) lvl[i] <= '0;
      out_q    <= '0;
      free_cnt <= CW'(LEVELS);
    end else if (save) begin
      for (int i = LEVELS - 1; i > 0; i--) lvl[i] <= lvl[i-1];
      lvl[0] <= {bank_in, psw_in};
      if (free_cnt != '0) free_cnt <= free_cnt - 1'b1;
    end else if (restore) begin
      out_q <= lvl[0];
      for (int i = 0; i < LEVELS - 1; i++) lvl[i] <= lvl[i+1];
      lvl[LEVELS-1] <= '0;
      if (free_cnt != CW'(LEVELS)) free_cnt <= free_cnt + 1'b1;
    end
  end

  assign bank_out = out_q[EW-1:SW];
  assign psw_out  = out_q[SW-1:0];
endmodule

// File: rtl/call_stack_unit.sv
module call_stack_unit
  import cstk_pkg::*;
#(
  parameter int DEPTH  = 5,
  parameter int AW     = 12,
  parameter int BW     = 4,
  parameter int SW     = 8,
  parameter int LEVELS = 3,
  localparam int CW    = $clog2(LEVELS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cmd,
  input  logic [AW-1:0]   push_data,
  input  logic [BW-1:0]   bank_in,
  input  logic [SW-1:0]   psw_in,
  output logic [AW-1:0]   pop_data,
  output logic [BW-1:0]   bank_out,
  output logic [SW-1:0]   psw_out,
  output logic [SP_W-1:0] sp_out,
  output logic [CW-1:0]   ctx_free,
  output logic            reset_req
);
  logic            do_push, do_pop, do_int, do_reti;
  logic [SP_W-1:0] sp_q, sp_nxt;
  logic            slot_wr;

  cstk_cmd_decode u_dec (
    .cmd(cmd), .do_push(do_push), .do_pop(do_pop),
    .do_int(do_int), .do_reti(do_reti)
  );

  assign sp_nxt  = sp_step(sp_q, do_push, do_pop);
  assign slot_wr = do_push && !sp_outside(sp_nxt, DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q      <= SP_W'(DEPTH);
      reset_req <= 1'b0;
    end else begin
      sp_q      <= sp_nxt;
      reset_req <= sp_fault(sp_q, DEPTH);
    end
  end

  cstk_addr_stack #(.DEPTH(DEPTH), .AW(AW), .SPW(SP_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_wr), .wr_idx(sp_nxt), .wr_data(push_data),
    .rd_en(do_pop), .rd_idx(sp_q), .rd_data(pop_data)
  );

  cstk_ctx_stack #(.LEVELS(LEVELS), .BW(BW), .SW(SW)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .save(do_int), .restore(do_reti),
    .bank_in(bank_in), .psw_in(psw_in),
    .bank_out(bank_out), .psw_out(psw_out), .free_cnt(ctx_free)
  );

  assign sp_out = sp_q;
endmodule

// File: rtl/cstk_checker.sv
module cstk_checker #(
  parameter int DEPTH  = 5,
  parameter int LEVELS = 3,
  parameter int AW     = 12,
  parameter int CW     = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          do_push,
  input logic          do_pop,
  input logic          do_int,
  input logic          do_reti,
  input logic [2:0]    sp_out,
  input logic [CW-1:0] ctx_free,
  input logic [AW-1:0] pop_data,
  input logic          reset_req
);
  AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> sp_out == 3'($past(sp_out) - 3'd1));                     // R2
  AST_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> sp_out == 3'($past(sp_out) + 3'd1));                      // R3
  AST_SP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_push && !do_pop) |=> $stable(sp_out));                           // R10
  AST_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !do_pop |=> $stable(pop_data));                                       // R3
  AST_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sp_out) > DEPTH) |=> reset_req);                                // R5
  AST_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sp_out) <= DEPTH) |=> !reset_req);                              // R5
  AST_CTX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_int && !do_reti) |=> $stable(ctx_free));                         // R8
  AST_CTX_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (do_int && ctx_free != '0) |=> ctx_free == CW'($past(ctx_free) - 1'b1)); // R8
  AST_CTX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (do_reti && int'(ctx_free) == LEVELS) |=> int'(ctx_free) == LEVELS);  // R9
endmodule

bind call_stack_unit cstk_checker #(
  .DEPTH(DEPTH), .LEVELS(LEVELS), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .do_push(do_push), .do_pop(do_pop), .do_int(do_int), .do_reti(do_reti),
  .sp_out(sp_out), .ctx_free(ctx_free), .pop_data(pop_data),
  .reset_req(reset_req)
);

// File: tb/call_stack_unit_bench.sv
`timescale 1ns/1ps
module call_stack_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [11:0] push_data = '0;
  logic [3:0]  bank_in = '0;
  logic [7:0]  psw_in = '0;
  logic [11:0] pop_data;
  logic [3:0]  bank_out;
  logic [7:0]  psw_out;
  logic [2:0]  sp_out;
  logic [1:0]  ctx_free;
  logic        reset_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  call_stack_unit u_call_stack_unit (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .push_data(push_data),
    .bank_in(bank_in), .psw_in(psw_in), .pop_data(pop_data),
    .bank_out(bank_out), .psw_out(psw_out), .sp_out(sp_out),
    .ctx_free(ctx_free), .reset_req(reset_req)
  );

  // reference model
  logic [2:0]  m_sp;
  logic [11:0] m_mem [5];
  logic [11:0] m_ctx [3];
  logic [1:0]  m_free;
  logic [11:0] m_pop;
  logic [11:0] m_rest;
  logic        m_req;

  function automatic bit is_store(input logic [3:0] c);
    return c >= 4'd1 && c <= 4'd5;
  endfunction
  function automatic bit is_fetch(input logic [3:0] c);
    return c >= 4'd6 && c <= 4'd10;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sp = 3'd5; m_free = 2'd3; m_pop = '0; m_rest = '0; m_req = 1'b0;
    for (int i = 0; i < 5; i++) m_mem[i] = '0;
    for (int i = 0; i < 3; i++) m_ctx[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd = 4'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk("R1", "sp_out", 32'(sp_out), 32'd5);
    chk("R1", "ctx_free", 32'(ctx_free), 32'd3);
    chk("R1", "reset_req", 32'(reset_req), 32'd0);
    chk("R1", "pop_data", 32'(pop_data), 32'd0);
    chk("R1", "bank/psw", 32'({bank_out, psw_out}), 32'd0);
  endtask

  // called at a falling edge; applies one command and checks after the next rising edge
  task automatic step(input logic [3:0] c, input logic [11:0] d,
                      input logic [3:0] b, input logic [7:0] p, input string req);
    logic [2:0] prev;
    prev = m_sp;
    cmd = c; push_data = d; bank_in = b; psw_in = p;
    if (is_store(c)) begin
      m_sp = m_sp - 3'd1;
      if (m_sp < 3'd5) m_mem[m_sp] = d;
    end else if (is_fetch(c)) begin
      m_pop = (m_sp < 3'd5) ? m_mem[m_sp] : 12'd0;
      m_sp  = m_sp + 3'd1;
    end
    if (c == 4'd5) begin
      m_ctx[2] = m_ctx[1]; m_ctx[1] = m_ctx[0]; m_ctx[0] = {b, p};
      if (m_free != 2'd0) m_free = m_free - 2'd1;
    end else if (c == 4'd10) begin
      m_rest = m_ctx[0];
      m_ctx[0] = m_ctx[1]; m_ctx[1] = m_ctx[2]; m_ctx[2] = '0;
      if (m_free != 2'd3) m_free = m_free + 2'd1;
    end
    m_req = (prev >= 3'd6);
    @(posedge clk);
    @(negedge clk);
    cmd = 4'd0;
    chk(req, "sp_out", 32'(sp_out), 32'(m_sp));
    chk(req, "pop_data", 32'(pop_data), 32'(m_pop));
    chk("R5", "reset_req", 32'(reset_req), 32'(m_req));
    chk("R8", "ctx_free", 32'(ctx_free), 32'(m_free));
    chk(req, "bank/psw", 32'({bank_out, psw_out}), 32'(m_rest));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R2 R3 R4: five stores with mixed codes, then five retrievals in reverse
    step(4'd1, 12'hA01, 4'h0, 8'h00, "R2");
    step(4'd2, 12'hB02, 4'h0, 8'h00, "R2");
    step(4'd3, 12'hC03, 4'h0, 8'h00, "R2");
    step(4'd4, 12'hD04, 4'h0, 8'h00, "R2");
    step(4'd1, 12'hE05, 4'h0, 8'h00, "R2");
    step(4'd6, 12'h000, 4'h0, 8'h00, "R4");
    chk("R4", "first out", 32'(pop_data), 32'h00000E05);
    step(4'd7, 12'h000, 4'h0, 8'h00, "R4");
    step(4'd8, 12'h000, 4'h0, 8'h00, "R4");
    step(4'd9, 12'h000, 4'h0, 8'h00, "R4");
    step(4'd6, 12'h000, 4'h0, 8'h00, "R4");
    chk("R4", "last out", 32'(pop_data), 32'h00000A01);

    // R5: retrieving from an empty stack moves the pointer to 6
    step(4'd6, 12'h000, 4'h0, 8'h00, "R3");
    step(4'd0, 12'h000, 4'h0, 8'h00, "R5");
    chk("R5", "req after 6", 32'(reset_req), 32'd1);
    do_reset();

    // R5: six nested stores wrap the pointer to 7
    for (int i = 0; i < 6; i++) step(4'd1, 12'(i + 1), 4'h0, 8'h00, "R2");
    chk("R2", "sp wrapped", 32'(sp_out), 32'd7);
    step(4'd0, 12'h000, 4'h0, 8'h00, "R5");
    do_reset();

    // R6 R7: four nested interrupts, the first context is lost
    step(4'd5, 12'h101, 4'h1, 8'h11, "R6");
    step(4'd5, 12'h102, 4'h2, 8'h22, "R6");
    step(4'd5, 12'h103, 4'h3, 8'h33, "R7");
    step(4'd5, 12'h104, 4'h4, 8'h44, "R7");
    chk("R8", "ctx full", 32'(ctx_free), 32'd0);
    step(4'd10, 12'h000, 4'h0, 8'h00, "R6");
    chk("R6", "newest ctx", 32'({bank_out, psw_out}), 32'h00000444);
    step(4'd10, 12'h000, 4'h0, 8'h00, "R7");
    step(4'd10, 12'h000, 4'h0, 8'h00, "R7");
    chk("R7", "third ctx", 32'({bank_out, psw_out}), 32'h00000222);
    step(4'd10, 12'h000, 4'h0, 8'h00, "R9");
    chk("R9", "lost ctx reads zero", 32'({bank_out, psw_out}), 32'd0);
    chk("R9", "free stays", 32'(ctx_free), 32'd3);

    // R10: unused codes leave every output alone
    step(4'd3, 12'h5A5, 4'h0, 8'h00, "R2");
    step(4'd9, 12'h000, 4'h0, 8'h00, "R3");
    for (int c = 11; c < 16; c++) step(4'(c), 12'hFFF, 4'hF, 8'hFF, "R10");
    step(4'd0, 12'hFFF, 4'hF, 8'hFF, "R10");
    chk("R10", "pop_data kept", 32'(pop_data), 32'h000005A5);

    // random mix, reset every 40 steps to re-centre the pointer
    for (int n = 0; n < 1200; n++) begin
      logic [3:0] rc;
      if (n % 40 == 0) do_reset();
      rc = 4'($urandom_range(0, 15));
      step(rc, 12'($urandom), 4'($urandom), 8'($urandom),
           is_store(rc) ? "R2" : is_fetch(rc) ? "R3" : "R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule